// File: doc/BRIEF.md
# Fixed-Point Subset Decode and Execute Unit

This block decodes and executes one 32-bit instruction per clock from a small fixed-point subset: add immediate, OR, load word and zero, store word, and store word with update. It holds a file of 32 general-purpose registers, each 64 bits wide. Decode, register read, address generation, the memory access and register write-back all happen in the cycle in which `instr_valid` is high. The register update commits at the rising clock edge that ends that cycle.

The memory side is a plain synchronous word port. The block drives a full-width byte address, a read strobe, a write strobe and 32 bits of write data. Read data must be returned combinationally in the same cycle, and a write is taken at the closing clock edge. Word data on this port is big-endian: bits 31:24 are the byte at the address.

A write-back bus shows the register index and value that will be written at the coming edge. Any valid word that matches none of the supported encodings raises `illegal` for that cycle and changes nothing.

Top module: `fxu_core`

## Requirements
- R1: An asynchronous active-low reset clears every register to zero, registers 1 and 31 included. While `instr_valid` is low, `mem_rd`, `mem_wr`, `wb_en` and `illegal` are all low.
- R2: Field positions within `instr` are as follows.
  - Primary opcode: `instr[31:26]`.
  - Target or source register: `instr[25:21]`.
  - Base register (A): `instr[20:16]`.
  - Second source (B): `instr[15:11]`.
  - 16-bit immediate: `instr[15:0]`.
  - Extended opcode: `instr[10:1]`.
  - `instr[0]` (record bit) is ignored.
- R3: Add immediate (opcode 14) writes the base plus the sign-extended immediate to the target register. The base is literal zero when the A field is 0, and register A otherwise. The same base rule applies to opcodes 32 and 36.
- R4: OR (opcode 31 with extended opcode 444) writes (source register) OR (register B) into register A. It uses no memory and gives the same result whatever `instr[0]` holds.
- R5: Load word and zero (opcode 32) raises `mem_rd` with `mem_addr` set to the effective address. It writes `mem_rdata` into the low 32 bits of the target register and zero into the upper 32 bits.
- R6: Store word (opcode 36) raises `mem_wr` with `mem_addr` set to the effective address and `mem_wdata` set to the low 32 bits of the source register. It writes no register.
- R7: Store word with update (opcode 37) always uses the contents of register A as the base, including when A is 0. It stores as R6 does and writes the effective address into register A.
- R8: The effective address is the base plus the sign-extended immediate, computed modulo 2^64. All 64 bits appear on `mem_addr`.
- R9: A valid word that matches none of the encodings above raises `illegal` for that cycle, with no memory strobe and no register write.
- R10: A word presented with `instr_valid` low has no effect on registers or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| illegal | output | 1 | Valid word is not a supported encoding |
| mem_addr | output | XLEN | Byte address of the memory access |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_wdata | output | 32 | Store data, big-endian |
| mem_rdata | input | 32 | Load data, same cycle, big-endian |
| wb_en | output | 1 | A register is written at the next edge |
| wb_idx | output | 5 | Index of the register written |
| wb_data | output | XLEN | Value written |

## Verification
The add-immediate and OR paths are each given a register whose value would change the result. Register 0 is deliberately made nonzero, so that literal-zero base selection is told apart from a read of register 0, and store-with-update on register 0 is told apart from the other forms. Negative displacements, a base of all ones and a displacement that carries past bit 63 separate a full-width sign-extended adder from a truncated or zero-extended one. A word with bit 31 set is stored and loaded back, which exposes any sign extension on load. Unknown primary and extended opcodes, followed by a read of the register they name, show that rejected words leave state untouched.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

   localparam int unsigned INSN_W   = 32;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned RIDX_W   = 5;
   localparam int unsigned IMM_W    = 16;
   localparam int unsigned SP_IDX   = 1;
   localparam int unsigned ENV_IDX  = 31;

   localparam logic [5:0] OPC_ADDI = 6'd14;
   localparam logic [5:0] OPC_XO   = 6'd31;
   localparam logic [5:0] OPC_LDW  = 6'd32;
   localparam logic [5:0] OPC_STW  = 6'd36;
   localparam logic [5:0] OPC_STWU = 6'd37;
   localparam logic [9:0] XO_OR    = 10'd444;

   typedef enum logic [2:0] {
      K_NONE,
      K_ADDI,
      K_OR,
      K_LOAD,
      K_STORE,
      K_STORE_UPD,
      K_ILLEGAL
   } kind_e;

   typedef struct packed {
      kind_e              kind;
      logic [RIDX_W-1:0]  rt;
      logic [RIDX_W-1:0]  ra;
      logic [RIDX_W-1:0]  rb;
      logic [IMM_W-1:0]   imm;
   } dec_t;

endpackage

// File: rtl/fxu_decode.sv
module fxu_decode
   import fxu_pkg::*;
(
   input  logic              valid,
   input  logic [INSN_W-1:0] word,
   output dec_t              dec
);

   logic [5:0] opc;
   logic [9:0] xop;
   logic       unused_rc;

   assign opc       = word[31:26];
   assign xop       = word[10:1];
   assign unused_rc = word[0];

   always_comb begin
      dec.rt  = word[25:21];
      dec.ra  = word[20:16];
      dec.rb  = word[15:11];
      dec.imm = word[15:0];
      if (!valid) begin
         dec.kind = K_NONE;
      end else begin
         unique case (opc)
            OPC_ADDI: dec.kind = K_ADDI;
            OPC_LDW:  dec.kind = K_LOAD;
            OPC_STW:  dec.kind = K_STORE;
            OPC_STWU: dec.kind = K_STORE_UPD;
            OPC_XO:   dec.kind = (xop == XO_OR) ? K_OR : K_ILLEGAL;
            default:  dec.kind = K_ILLEGAL;
         endcase
      end
   end

endmodule

// File: rtl/fxu_regfile.sv
module fxu_regfile
   import fxu_pkg::*;
#(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned N_RD      = 3,
   parameter bit          RESET_ALL = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N_RD-1:0][IDX_W-1:0]     raddr,
   output logic [N_RD-1:0][XLEN-1:0]      rdata,
   input  logic                           we,
   input  logic [IDX_W-1:0]               waddr,
   input  logic [XLEN-1:0]                wdata
);

   localparam int unsigned N_REGS = 1 << IDX_W;

   logic [N_REGS*XLEN-1:0] flat;

   for (genvar g = 0; g < N_REGS; g++) begin : g_reg
      logic [XLEN-1:0] q;
      logic            hit;
      assign hit = we && (waddr == IDX_W'(g));
      if (RESET_ALL || g == SP_IDX || g == ENV_IDX) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (hit) begin
               q <= wdata;
            end
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (hit) begin
               q <= wdata;
            end
         end
      end
      assign flat[g*XLEN +: XLEN] = q;
   end

   for (genvar p = 0; p < N_RD; p++) begin : g_rd
      assign rdata[p] = flat[raddr[p]*XLEN +: XLEN];
   end

endmodule

// File: rtl/fxu_agen.sv
module fxu_agen
   import fxu_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [RIDX_W-1:0] base_idx,
   input  logic [XLEN-1:0]   base_val,
   input  logic              base_forced,
   input  logic [IMM_W-1:0]  disp,
   output logic [XLEN-1:0]   ea
);

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] disp_x;

   assign base   = (base_idx == '0 && !base_forced) ? '0 : base_val;
   assign disp_x = XLEN'($signed(disp));
   assign ea     = base + disp_x;

endmodule

// File: rtl/fxu_core.sv
module fxu_core
   import fxu_pkg::*;
#(
   parameter int unsigned XLEN      = 64,
   parameter bit          RESET_ALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr,
   output logic              illegal,
   output logic [XLEN-1:0]   mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              wb_en,
   output logic [4:0]        wb_idx,
   output logic [XLEN-1:0]   wb_data
);

   localparam int unsigned N_RD   = 3;
   localparam int unsigned PORT_A = 0;
   localparam int unsigned PORT_B = 1;
   localparam int unsigned PORT_S = 2;

   if (XLEN < WORD_W) begin : g_bad_xlen
      $error("fxu_core: XLEN must be at least the word width");
   end
   if (INSN_W != 32 || RIDX_W != 5) begin : g_bad_fmt
      $error("fxu_core: instruction format constants changed");
   end

   dec_t                         dec;
   logic [N_RD-1:0][RIDX_W-1:0]  rf_raddr;
   logic [N_RD-1:0][XLEN-1:0]    rf_rdata;
   logic [XLEN-1:0]              ea;

   fxu_decode i_decode (
      .valid (instr_valid),
      .word  (instr),
      .dec   (dec)
   );

   assign rf_raddr[PORT_A] = dec.ra;
   assign rf_raddr[PORT_B] = dec.rb;
   assign rf_raddr[PORT_S] = dec.rt;

   fxu_regfile #(
      .XLEN      (XLEN),
      .IDX_W     (RIDX_W),
      .N_RD      (N_RD),
      .RESET_ALL (RESET_ALL)
   ) i_regfile (
      .clk   (clk),
      .rst_n (rst_n),
      .raddr (rf_raddr),
      .rdata (rf_rdata),
      .we    (wb_en),
      .waddr (wb_idx),
      .wdata (wb_data)
   );

   fxu_agen #(
      .XLEN (XLEN)
   ) i_agen (
      .base_idx    (dec.ra),
      .base_val    (rf_rdata[PORT_A]),
      .base_forced (dec.kind == K_STORE_UPD),
      .disp        (dec.imm),
      .ea          (ea)
   );

   assign illegal   = (dec.kind == K_ILLEGAL);
   assign mem_rd    = (dec.kind == K_LOAD);
   assign mem_wr    = (dec.kind == K_STORE) || (dec.kind == K_STORE_UPD);
   assign mem_addr  = ea;
   assign mem_wdata = rf_rdata[PORT_S][WORD_W-1:0];

   always_comb begin
      wb_en   = 1'b0;
      wb_idx  = dec.rt;
      wb_data = ea;
      unique case (dec.kind)
         K_ADDI: begin
            wb_en = 1'b1;
         end
         K_OR: begin
            wb_en   = 1'b1;
            wb_idx  = dec.ra;
            wb_data = rf_rdata[PORT_S] | rf_rdata[PORT_B];
         end
         K_LOAD: begin
            wb_en   = 1'b1;
            wb_data = XLEN'(mem_rdata);
         end
         K_STORE_UPD: begin
            wb_en  = 1'b1;
            wb_idx = dec.ra;
         end
         default: begin
            wb_en = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/fxu_core_chk.sv
module fxu_core_chk
   import fxu_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic [31:0]       instr,
   input logic              illegal,
   input logic [XLEN-1:0]   mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [31:0]       mem_rdata,
   input logic              wb_en,
   input logic [4:0]        wb_idx,
   input logic [XLEN-1:0]   wb_data
);

   logic [5:0] opc;
   assign opc = instr[31:26];

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> !illegal && !mem_rd && !mem_wr && !wb_en); // R10

   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !mem_rd && !mem_wr && !wb_en); // R9

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({illegal, mem_rd, mem_wr})); // R9

   AST_LOAD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> wb_en && wb_idx == instr[25:21]
                 && wb_data == XLEN'(mem_rdata)); // R5

   AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && opc == OPC_STW) |-> !wb_en); // R6

   AST_UPD_WRITES_EA: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && opc == OPC_STWU) |-> wb_en && wb_idx == instr[20:16]
                                      && wb_data == mem_addr); // R7

   AST_OR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && opc == OPC_XO) |-> !mem_rd && !mem_wr
                                   && wb_idx == instr[20:16]); // R4

endmodule

bind fxu_core fxu_core_chk #(.XLEN(XLEN)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr       (instr),
   .illegal     (illegal),
   .mem_addr    (mem_addr),
   .mem_rd      (mem_rd),
   .mem_wr      (mem_wr),
   .mem_rdata   (mem_rdata),
   .wb_en       (wb_en),
   .wb_idx      (wb_idx),
   .wb_data     (wb_data)
);

// File: tb/test_fxu_core.sv
module test_fxu_core;

   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic            illegal;
   logic [XLEN-1:0] mem_addr;
   logic            mem_rd;
   logic            mem_wr;
   logic [31:0]     mem_wdata;
   logic [31:0]     mem_rdata;
   logic            wb_en;
   logic [4:0]      wb_idx;
   logic [XLEN-1:0] wb_data;

   always #4 clk = ~clk;   // 125 MHz

   fxu_core #(.XLEN(XLEN)) i_fxu_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr       (instr),
      .illegal     (illegal),
      .mem_addr    (mem_addr),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata),
      .wb_en       (wb_en),
      .wb_idx      (wb_idx),
      .wb_data     (wb_data)
   );

   // behavioural big-endian byte memory, 256 bytes, address wraps
   logic [7:0] bmem [256];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) bmem[i] <= 8'h00;
      end else if (mem_wr) begin
         bmem[mem_addr[7:0]]         <= mem_wdata[31:24];
         bmem[mem_addr[7:0] + 8'd1]  <= mem_wdata[23:16];
         bmem[mem_addr[7:0] + 8'd2]  <= mem_wdata[15:8];
         bmem[mem_addr[7:0] + 8'd3]  <= mem_wdata[7:0];
      end
   end

   always_comb begin
      mem_rdata = {bmem[mem_addr[7:0]], bmem[mem_addr[7:0] + 8'd1],
                   bmem[mem_addr[7:0] + 8'd2], bmem[mem_addr[7:0] + 8'd3]};
   end

   typedef struct packed {
      logic        ill;
      logic        rd;
      logic        wr;
      logic [63:0] addr;
      logic [31:0] wdata;
      logic        wb;
      logic [4:0]  idx;
      logic [63:0] data;
   } exp_t;

   exp_t        exp_q[$];
   string       tag_q[$];
   logic [63:0] mreg [32];
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   exp_t        cur;
   string       cur_tag;

   function automatic logic [31:0] dform(input logic [5:0] op, input logic [4:0] t,
                                         input logic [4:0] a, input logic [15:0] d);
      return {op, t, a, d};
   endfunction

   function automatic logic [31:0] orform(input logic [4:0] s, input logic [4:0] a,
                                          input logic [4:0] b, input logic rc);
      return {6'd31, s, a, b, 10'd444, rc};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // driver: presents one word for one cycle and queues the expected outcome
   task automatic issue(input logic [31:0] w, input string tag, input logic v = 1'b1);
      exp_t        e;
      logic [63:0] sx;
      logic [63:0] base;
      @(negedge clk);
      instr_valid = v;
      instr       = w;
      e    = '0;
      sx   = {{48{w[15]}}, w[15:0]};
      base = (w[20:16] == 5'd0) ? 64'd0 : mreg[w[20:16]];
      if (v) begin
         case (w[31:26])
            6'd14: begin e.wb = 1'b1; e.idx = w[25:21]; e.data = base + sx; end
            6'd31: begin
               if (w[10:1] == 10'd444) begin
                  e.wb = 1'b1; e.idx = w[20:16];
                  e.data = mreg[w[25:21]] | mreg[w[15:11]];
               end else begin
                  e.ill = 1'b1;
               end
            end
            6'd32: begin
               e.rd = 1'b1; e.addr = base + sx; e.wb = 1'b1; e.idx = w[25:21];
               e.data = {32'd0, bmem[e.addr[7:0]], bmem[e.addr[7:0] + 8'd1],
                         bmem[e.addr[7:0] + 8'd2], bmem[e.addr[7:0] + 8'd3]};
            end
            6'd36: begin
               e.wr = 1'b1; e.addr = base + sx; e.wdata = mreg[w[25:21]][31:0];
            end
            6'd37: begin
               e.wr = 1'b1; e.addr = mreg[w[20:16]] + sx;
               e.wdata = mreg[w[25:21]][31:0];
               e.wb = 1'b1; e.idx = w[20:16]; e.data = e.addr;
            end
            default: e.ill = 1'b1;
         endcase
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (e.wb) mreg[e.idx] = e.data;
   endtask

   // monitor: compares outputs mid-cycle against the queued expectation
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() != 0) begin
            cur     = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
            chk(cur_tag, "illegal", 64'(illegal), 64'(cur.ill));
            chk(cur_tag, "mem_rd",  64'(mem_rd),  64'(cur.rd));
            chk(cur_tag, "mem_wr",  64'(mem_wr),  64'(cur.wr));
            chk(cur_tag, "wb_en",   64'(wb_en),   64'(cur.wb));
            if (cur.rd || cur.wr) chk(cur_tag, "mem_addr", mem_addr, cur.addr);
            if (cur.wr) chk(cur_tag, "mem_wdata", 64'(mem_wdata), 64'(cur.wdata));
            if (cur.wb) begin
               chk(cur_tag, "wb_idx",  64'(wb_idx), 64'(cur.idx));
               chk(cur_tag, "wb_data", wb_data, cur.data);
            end
         end
      end
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) mreg[i] = 64'd0;
      instr = dform(6'd14, 5'd3, 5'd0, 16'h0001);
      repeat (3) @(negedge clk);
      #2;
      // R1: reset, no valid word, all outputs idle
      chk("R1 reset", "illegal", 64'(illegal), 64'd0);
      chk("R1 reset", "mem_rd",  64'(mem_rd),  64'd0);
      chk("R1 reset", "mem_wr",  64'(mem_wr),  64'd0);
      chk("R1 reset", "wb_en",   64'(wb_en),   64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      issue(dform(6'd14, 5'd1, 5'd1, 16'h0001), "R1 reg1 cleared");
      issue(dform(6'd14, 5'd2, 5'd31, 16'hFFFF), "R1 reg31 cleared R8 sext");
      issue(dform(6'd14, 5'd0, 5'd0, 16'h0020), "R3 write reg0");
      issue(dform(6'd14, 5'd3, 5'd0, 16'hFFFB), "R3 literal zero base");
      issue(dform(6'd14, 5'd4, 5'd3, 16'h7FFF), "R3 register base R2");
      issue(orform(5'd4, 5'd5, 5'd1, 1'b0), "R4 or");
      issue(orform(5'd1, 5'd6, 5'd0, 1'b1), "R4 or record bit R2");
      issue(dform(6'd36, 5'd3, 5'd0, 16'h0040), "R6 store zero base R3");
      issue(dform(6'd32, 5'd7, 5'd0, 16'h0040), "R5 load zero extend");
      issue(dform(6'd14, 5'd8, 5'd0, 16'h0100), "R3 set base");
      issue(dform(6'd36, 5'd5, 5'd8, 16'hFFF0), "R8 negative disp R6");
      issue(dform(6'd32, 5'd9, 5'd8, 16'hFFF0), "R5 load back");
      issue(dform(6'd37, 5'd4, 5'd8, 16'h0008), "R7 store update");
      issue(dform(6'd37, 5'd1, 5'd0, 16'h0004), "R7 update uses reg0");
      issue(dform(6'd14, 5'd11, 5'd0, 16'h0001), "R3 zero base after R7");
      issue(dform(6'd36, 5'd1, 5'd2, 16'h0000), "R8 all ones address");
      issue(dform(6'd36, 5'd6, 5'd2, 16'h7FFF), "R8 wrap past bit 63");
      issue(32'h0000_0000, "R9 opcode zero");
      issue({6'd31, 5'd3, 5'd5, 5'd4, 10'd266, 1'b0}, "R9 unknown ext op");
      issue(dform(6'd38, 5'd5, 5'd0, 16'h0010), "R9 unknown opcode");
      issue(dform(6'd14, 5'd10, 5'd5, 16'h0000), "R9 reg5 unchanged");
      issue(dform(6'd14, 5'd5, 5'd0, 16'h0000), "R10 invalid addi", 1'b0);
      issue(dform(6'd36, 5'd1, 5'd0, 16'h0040), "R10 invalid store", 1'b0);
      issue(dform(6'd32, 5'd12, 5'd0, 16'h0040), "R10 memory kept");
      issue(dform(6'd14, 5'd13, 5'd5, 16'h0000), "R10 reg5 kept");
      issue(32'h0000_0000, "R10 idle tail", 1'b0);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule